// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

The sequencer takes one DMA transfer at a time, described by a byte start address, a byte count and a direction (load or store). It cuts the transfer into segments that never cross a cache-line boundary and hands them, strictly one at a time, to a line-level controller downstream. The first segment may begin part-way into a line and is clipped at the line end; every segment after it begins on a line boundary and is as long as a line or as the bytes still owed, whichever is smaller.

For a store, the caller's bytes travel with the request in a flat buffer. The sequencer places each segment's bytes on the matching byte lanes of a line-wide data bus and marks them in a byte-enable mask. For a load, the controller returns a full line. The sequencer takes the segment's bytes from the correct lanes and packs them into its buffer at the running byte position. That buffer is visible to the caller on `rd_buf`. A one-cycle `done` pulse marks the end of the transfer.

The request port and the segment port are valid/ready. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low for the whole of an active transfer, and a request offered then is not queued: the caller must offer it again. A segment is held with all fields stable while `seg_valid` is high and `seg_ready` is low. The return strobes `wr_ack` and `rd_valid` are single-cycle and have no ready.

Top module: `dma_line_seq`

## Requirements
- R1: After reset `busy`, `seg_valid`, `done` and `req_err` are low and `req_ready` is high.
- R2: While a transfer is active `req_ready` is low. A request offered during that time is dropped, not held: once the transfer ends, no segment is issued for it.
- R3: `req_type` uses the codes 0 none, 1 load, 2 store, 3 fetch, 4 locked read, 5 locked write, 6 read-modify-write read and 7 read-modify-write write. Only codes 1 and 2 start a transfer. Any other code is consumed, raises `req_err` for one cycle in the cycle after acceptance, and issues no segment.
- R4: The first segment's byte address is the start address. Its length is the request length when (start address mod line size) plus length is no more than the line size, and otherwise the line size minus that offset.
- R5: Every later segment starts at start address plus bytes completed, which is line-aligned. Its length is the smaller of the remaining bytes and the line size. `seg_line` is always `seg_addr` with its low log2(line size) bits cleared.
- R6: Only one segment is outstanding at a time. After a segment handshake, `seg_valid` stays low until the matching return arrives: `wr_ack` for a store, `rd_valid` for a load. A return of the other kind is ignored.
- R7: For a store segment, byte lanes offset through offset+length-1 carry buffer bytes starting at index bytes-completed and have their `seg_be` bits set, with all other `seg_be` bits clear. The offset is the start offset for the first segment and 0 afterwards.
- R8: For a load, buffer bytes from bytes-completed up to bytes-issued are taken from `rd_line` starting at lane offset. The offset is the start offset for the first segment and 0 afterwards. At `done`, `rd_buf` byte k holds the byte read for address start+k.
- R9: `done` rises for one cycle in the cycle after the return that brings bytes completed up to the request length. In that same cycle `busy` is low and `req_ready` is high.
- R10: A load or store with length 0, or with a length above the buffer size, is refused in the same way as an illegal type: `req_err` pulses and no segment is issued.
- R11: `seg_store` is 1 for every segment of a store and 0 for every segment of a load.
- R12: While `seg_valid` is high and `seg_ready` is low, `seg_valid` stays high and the segment address, length and type hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_type | input | 3 | Request kind code (see R3) |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_wdata | input | BUF_BYTES*8 | Store bytes, byte k at bits 8k+7:8k |
| req_err | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_buf | output | BUF_BYTES*8 | Packed load bytes, byte k at bits 8k+7:8k |
| seg_valid | output | 1 | Segment offered downstream |
| seg_ready | input | 1 | Downstream takes the segment |
| seg_addr | output | ADDR_W | Segment byte address |
| seg_line | output | ADDR_W | Segment line address |
| seg_len | output | LEN_W | Segment byte count |
| seg_store | output | 1 | 1 store, 0 load |
| seg_be | output | LINE_BYTES | Byte-lane enables |
| seg_data | output | LINE_BYTES*8 | Store data by lane |
| wr_ack | input | 1 | Store segment acknowledged |
| rd_valid | input | 1 | Load segment data returned |
| rd_line | input | LINE_BYTES*8 | Returned line data by lane |

## Verification
The assertions check on every cycle the rules that hold whatever the traffic. A request is never accepted while busy. Each segment fits inside one line, with the first starting at the request address and every later one starting on a line boundary. The enable count equals the segment length. A handshaken segment is followed by an idle segment port, an offered segment holds steady under back-pressure, and `done` coincides with the idle state. Only the bench's scenarios can show the values that depend on the request itself: the exact segment sequence for mid-line, in-line and aligned transfers, byte lanes carrying the right store bytes, load bytes landing at the right buffer positions, refusal of illegal kinds and lengths, and that a request offered while busy is lost rather than queued.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    RQ_NONE    = 3'd0,
    RQ_LOAD    = 3'd1,
    RQ_STORE   = 3'd2,
    RQ_FETCH   = 3'd3,
    RQ_LOCK_RD = 3'd4,
    RQ_LOCK_WR = 3'd5,
    RQ_RMW_RD  = 3'd6,
    RQ_RMW_WR  = 3'd7
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dma_seg_calc.sv
// Segment geometry: address, line address, in-line offset and length of the
// segment that starts after done_bytes of the transfer.
module dma_seg_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 8
) (
  input  logic [ADDR_W-1:0]             start_addr,
  input  logic [LEN_W-1:0]              total_len,
  input  logic [LEN_W-1:0]              done_bytes,
  output logic [ADDR_W-1:0]             seg_addr,
  output logic [ADDR_W-1:0]             seg_line,
  output logic [$clog2(LINE_BYTES)-1:0] seg_off,
  output logic [LEN_W-1:0]              seg_len
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int SUM_W = LEN_W + 1;

  logic                 first;
  logic [OFF_W-1:0]     off_start;
  logic [SUM_W-1:0]     remain;
  logic [SUM_W-1:0]     room;

  always_comb begin
    first     = (done_bytes == '0);
    off_start = start_addr[OFF_W-1:0];
    seg_addr  = start_addr + ADDR_W'(done_bytes);
    seg_line  = {seg_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    seg_off   = first ? off_start : '0;
    remain    = SUM_W'(total_len) - SUM_W'(done_bytes);
    room      = first ? (SUM_W'(LINE_BYTES) - SUM_W'(off_start))
                      : SUM_W'(LINE_BYTES);
    seg_len   = LEN_W'((remain < room) ? remain : room);
  end

endmodule

// File: rtl/dma_seg_buffer.sv
// Transfer byte buffer: loaded with store data at acceptance, gathered onto
// line lanes for store segments, scattered into from returned load lines.
module dma_seg_buffer #(
  parameter int LINE_BYTES = 64,
  parameter int BUF_BYTES  = 128,
  parameter int LEN_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_en,
  input  logic [BUF_BYTES*8-1:0]        load_data,
  input  logic [LEN_W-1:0]              gather_base,
  input  logic [$clog2(LINE_BYTES)-1:0] gather_off,
  input  logic [LEN_W-1:0]              gather_len,
  output logic [LINE_BYTES*8-1:0]       line_data,
  output logic [LINE_BYTES-1:0]         line_be,
  input  logic                          cap_en,
  input  logic [LINE_BYTES*8-1:0]       cap_line,
  input  logic [LEN_W-1:0]              cap_base,
  input  logic [LEN_W-1:0]              cap_cnt,
  input  logic [$clog2(LINE_BYTES)-1:0] cap_off,
  output logic [BUF_BYTES*8-1:0]        buf_flat
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int BI_W  = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1;

  logic [7:0] mem_q [BUF_BYTES];

  // Gather: lane j carries buffer byte base + (j - off) when inside the segment.
  always_comb begin
    for (int j = 0; j < LINE_BYTES; j++) begin
      automatic int src = int'(gather_base) + j - int'(gather_off);
      line_data[j*8 +: 8] = 8'h00;
      line_be[j]          = 1'b0;
      if (j >= int'(gather_off) && j < int'(gather_off) + int'(gather_len)) begin
        line_be[j] = 1'b1;
        if (src >= 0 && src < BUF_BYTES) line_data[j*8 +: 8] = mem_q[BI_W'(src)];
      end
    end
  end

  // Scatter: buffer byte k takes lane (k - base + off) of the returned line.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < BUF_BYTES; k++) mem_q[k] <= 8'h00;
    end else if (load_en) begin
      for (int k = 0; k < BUF_BYTES; k++) mem_q[k] <= load_data[k*8 +: 8];
    end else if (cap_en) begin
      for (int k = 0; k < BUF_BYTES; k++) begin
        if (k >= int'(cap_base) && k < int'(cap_base) + int'(cap_cnt)) begin
          mem_q[k] <= cap_line[{OFF_W'(k - int'(cap_base) + int'(cap_off)), 3'b000} +: 8];
        end
      end
    end
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_flat
    assign buf_flat[g*8 +: 8] = mem_q[g];
  end

endmodule

// File: rtl/dma_line_seq.sv
module dma_line_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BUF_BYTES  = 128,
  parameter int LEN_W      = $clog2(BUF_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_type,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [BUF_BYTES*8-1:0]  req_wdata,
  output logic                    req_err,
  output logic                    busy,
  output logic                    done,
  output logic [BUF_BYTES*8-1:0]  rd_buf,
  output logic                    seg_valid,
  input  logic                    seg_ready,
  output logic [ADDR_W-1:0]       seg_addr,
  output logic [ADDR_W-1:0]       seg_line,
  output logic [LEN_W-1:0]        seg_len,
  output logic                    seg_store,
  output logic [LINE_BYTES-1:0]   seg_be,
  output logic [LINE_BYTES*8-1:0] seg_data,
  input  logic                    wr_ack,
  input  logic                    rd_valid,
  input  logic [LINE_BYTES*8-1:0] rd_line
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  iss_q;
  logic [LEN_W-1:0]  cmp_q;
  logic              store_q;
  logic              done_q;
  logic              err_q;

  logic              accept;
  logic              legal;
  logic              ret;
  logic [OFF_W-1:0]  seg_off;

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign seg_valid = (state_q == ST_SEND);
  assign seg_store = store_q;
  assign done      = done_q;
  assign req_err   = err_q;

  assign accept = req_valid && req_ready;
  assign legal  = (req_type == RQ_LOAD || req_type == RQ_STORE) &&
                  (req_len != '0) && (int'(req_len) <= BUF_BYTES);
  assign ret    = (state_q == ST_WAIT) && (store_q ? wr_ack : rd_valid);

  dma_seg_calc #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)
  ) u_calc (
    .start_addr (start_q),
    .total_len  (len_q),
    .done_bytes (cmp_q),
    .seg_addr   (seg_addr),
    .seg_line   (seg_line),
    .seg_off    (seg_off),
    .seg_len    (seg_len)
  );

  dma_seg_buffer #(
    .LINE_BYTES(LINE_BYTES), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (accept && legal),
    .load_data   (req_wdata),
    .gather_base (cmp_q),
    .gather_off  (seg_off),
    .gather_len  (seg_len),
    .line_data   (seg_data),
    .line_be     (seg_be),
    .cap_en      (ret && !store_q),
    .cap_line    (rd_line),
    .cap_base    (cmp_q),
    .cap_cnt     (iss_q - cmp_q),
    .cap_off     (seg_off),
    .buf_flat    (rd_buf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= '0;
      len_q   <= '0;
      iss_q   <= '0;
      cmp_q   <= '0;
      store_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (legal) begin
              start_q <= req_addr;
              len_q   <= req_len;
              store_q <= (req_type == RQ_STORE);
              iss_q   <= '0;
              cmp_q   <= '0;
              state_q <= ST_SEND;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_SEND: begin
          if (seg_ready) begin
            iss_q   <= iss_q + seg_len;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ret) begin
            cmp_q <= iss_q;
            if (iss_q == len_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_SEND;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_line_seq_chk.sv
module dma_line_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  req_ready,
  input logic                  done,
  input logic                  seg_valid,
  input logic                  seg_ready,
  input logic [ADDR_W-1:0]     seg_addr,
  input logic [LEN_W-1:0]      seg_len,
  input logic                  seg_store,
  input logic [LINE_BYTES-1:0] seg_be,
  input logic [LEN_W-1:0]      cmp_bytes,
  input logic [ADDR_W-1:0]     start_addr
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  AST_REQ_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R2

  AST_FIRST_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && cmp_bytes == '0) |-> (seg_addr == start_addr)); // R4

  AST_SEG_FITS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_len != '0 &&
                   int'(seg_addr[OFF_W-1:0]) + int'(seg_len) <= LINE_BYTES)); // R4

  AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && cmp_bytes != '0) |-> (seg_addr[OFF_W-1:0] == '0)); // R5

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready) |=> !seg_valid); // R6

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> ($countones(seg_be) == int'(seg_len))); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && req_ready)); // R9

  AST_SEG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) &&
                                   $stable(seg_len) && $stable(seg_store))); // R12

endmodule

bind dma_line_seq dma_line_seq_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .req_ready  (req_ready),
  .done       (done),
  .seg_valid  (seg_valid),
  .seg_ready  (seg_ready),
  .seg_addr   (seg_addr),
  .seg_len    (seg_len),
  .seg_store  (seg_store),
  .seg_be     (seg_be),
  .cmp_bytes  (cmp_q),
  .start_addr (start_q)
);

// File: tb/dma_line_seq_test.sv
`timescale 1ns/1ps
module dma_line_seq_test;
  localparam int ADDR_W = 32;
  localparam int LINE   = 16;
  localparam int BUFB   = 64;
  localparam int LEN_W  = $clog2(BUFB + 1);

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   req_valid = 1'b0;
  logic                   req_ready;
  logic [2:0]             req_type = '0;
  logic [ADDR_W-1:0]      req_addr = '0;
  logic [LEN_W-1:0]       req_len = '0;
  logic [BUFB*8-1:0]      req_wdata = '0;
  logic                   req_err, busy, done;
  logic [BUFB*8-1:0]      rd_buf;
  logic                   seg_valid;
  logic                   seg_ready = 1'b0;
  logic [ADDR_W-1:0]      seg_addr, seg_line;
  logic [LEN_W-1:0]       seg_len;
  logic                   seg_store;
  logic [LINE-1:0]        seg_be;
  logic [LINE*8-1:0]      seg_data;
  logic                   wr_ack = 1'b0;
  logic                   rd_valid = 1'b0;
  logic [LINE*8-1:0]      rd_line = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_line_seq #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE), .BUF_BYTES(BUFB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .req_err(req_err), .busy(busy), .done(done),
    .rd_buf(rd_buf), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_line(seg_line), .seg_len(seg_len),
    .seg_store(seg_store), .seg_be(seg_be), .seg_data(seg_data),
    .wr_ack(wr_ack), .rd_valid(rd_valid), .rd_line(rd_line));

  function automatic logic [7:0] memf(input logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd7 + 8'd3) ^ a[15:8];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Generic transfer with a downstream model; hold = back-pressure cycles per
  // segment, poke = offer a second request while busy.
  task automatic do_xfer(input bit store, input logic [ADDR_W-1:0] addr,
                         input int len, input int hold, input bit poke,
                         input logic [7:0] seed);
    int done_b;
    done_b = 0;
    for (int k = 0; k < BUFB; k++) req_wdata[k*8 +: 8] = seed + 8'(k * 13);
    @(negedge clk);
    req_valid = 1'b1; req_type = store ? 3'd2 : 3'd1;
    req_addr = addr; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1 && req_ready == 1'b0, "R2", "busy after accept", busy, 1);
    while (done_b < len) begin
      int off, exp_len, mism;
      logic [ADDR_W-1:0] exp_addr, a0;
      off      = (done_b == 0) ? int'(addr % LINE) : 0;
      exp_len  = (len - done_b < LINE - off) ? len - done_b : LINE - off;
      exp_addr = addr + ADDR_W'(done_b);
      chk(seg_valid == 1'b1, "R6", "segment offered", seg_valid, 1);
      if (hold > 0) begin
        a0 = seg_addr;
        for (int h = 0; h < hold; h++) @(negedge clk);
        chk(seg_valid == 1'b1 && seg_addr == a0, "R12", "held under back-pressure",
            seg_addr, a0);
      end
      chk(seg_addr == exp_addr, (done_b == 0) ? "R4" : "R5", "seg_addr",
          seg_addr, exp_addr);
      chk(seg_line == (exp_addr & ~ADDR_W'(LINE - 1)), "R5", "seg_line",
          seg_line, exp_addr & ~ADDR_W'(LINE - 1));
      chk(int'(seg_len) == exp_len, (done_b == 0) ? "R4" : "R5", "seg_len",
          seg_len, exp_len);
      chk(seg_store == store, "R11", "seg_store", seg_store, store);
      if (store) begin
        mism = 0;
        for (int j = 0; j < LINE; j++) begin
          bit en;
          en = (j >= off) && (j < off + exp_len);
          if (seg_be[j] != en) mism++;
          if (en && seg_data[j*8 +: 8] != 8'(seed + 8'((done_b + j - off) * 13))) mism++;
        end
        chk(mism == 0, "R7", "store lanes/enables mismatches", mism, 0);
      end
      seg_ready = 1'b1;
      @(negedge clk);
      seg_ready = 1'b0;
      chk(seg_valid == 1'b0, "R6", "no segment while outstanding", seg_valid, 0);
      if (poke) begin
        req_valid = 1'b1; req_type = 3'd1; req_addr = 32'h900; req_len = 7'd4;
      end
      if (!store) wr_ack = 1'b1;
      @(negedge clk);
      wr_ack = 1'b0;
      chk(seg_valid == 1'b0, "R6", "wrong-kind return ignored", seg_valid, 0);
      if (poke) chk(req_ready == 1'b0, "R2", "req_ready while busy", req_ready, 0);
      @(negedge clk);
      req_valid = 1'b0;
      if (store) wr_ack = 1'b1;
      else begin
        rd_valid = 1'b1;
        for (int j = 0; j < LINE; j++)
          rd_line[j*8 +: 8] = memf((exp_addr & ~ADDR_W'(LINE - 1)) + ADDR_W'(j));
      end
      @(negedge clk);
      wr_ack = 1'b0; rd_valid = 1'b0;
      done_b += exp_len;
      if (done_b >= len)
        chk(done == 1'b1 && busy == 1'b0 && req_ready == 1'b1, "R9",
            "done with idle", {done, busy, req_ready}, 3'b101);
      else
        chk(done == 1'b0, "R9", "no early done", done, 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done is one cycle", done, 0);
    if (!store) begin
      int mism;
      mism = 0;
      for (int k = 0; k < len; k++)
        if (rd_buf[k*8 +: 8] != memf(addr + ADDR_W'(k))) mism++;
      chk(mism == 0, "R8", "load buffer mismatches", mism, 0);
    end
    if (poke) begin
      for (int c = 0; c < 3; c++) @(negedge clk);
      chk(seg_valid == 1'b0 && busy == 1'b0, "R2", "refused request not queued",
          {seg_valid, busy}, 0);
    end
  endtask

  task automatic t_reset();
    chk(busy == 0 && seg_valid == 0 && done == 0 && req_err == 0 && req_ready == 1,
        "R1", "reset outputs", {busy, seg_valid, done, req_err, req_ready}, 5'b00001);
  endtask

  task automatic t_reject(input logic [2:0] kind, input int len, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_type = kind; req_addr = 32'h40; req_len = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_err == 1'b1 && busy == 1'b0 && seg_valid == 1'b0, req, "refused",
        {req_err, busy, seg_valid}, 3'b100);
    @(negedge clk);
    chk(req_err == 1'b0 && seg_valid == 1'b0, req, "err single pulse, no segment",
        {req_err, seg_valid}, 0);
  endtask

  task automatic t_store_mid();     do_xfer(1'b1, 32'h105, 30, 0, 1'b0, 8'h11); endtask
  task automatic t_load_mid();      do_xfer(1'b0, 32'h20A, 40, 0, 1'b0, 8'h00); endtask
  task automatic t_in_line();       do_xfer(1'b0, 32'h333, 4, 0, 1'b0, 8'h00); endtask
  task automatic t_aligned_store(); do_xfer(1'b1, 32'h400, 32, 0, 1'b0, 8'h5A); endtask
  task automatic t_backpressure();  do_xfer(1'b1, 32'h50E, 20, 3, 1'b0, 8'h77); endtask
  task automatic t_busy_refuse();   do_xfer(1'b0, 32'h61C, 9, 0, 1'b1, 8'h00); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store_mid();
    t_load_mid();
    t_in_line();
    t_aligned_store();
    t_backpressure();
    t_busy_refuse();
    // R3: every kind other than load/store is refused
    t_reject(3'd0, 8, "R3");
    for (int t = 3; t < 8; t++) t_reject(3'(t), 8, "R3");
    // R10: bad lengths
    t_reject(3'd1, 0, "R10");
    t_reject(3'd2, BUFB + 1, "R10");
    summary();
  end

endmodule